// File: doc/BRIEF.md
# Clear-on-read interrupt status controller

This block gathers single-cycle event pulses from several on-chip sources into an 8-bit status register. It raises one interrupt line when any latched bit is enabled by a per-bit enable register and the global enable is on. Software reaches it through a synchronous register port with an address, a read strobe, a write strobe and write data. Read data appears one cycle after the strobe.

Reading the status register returns the latched bits and clears them in the same cycle. An event that arrives together with that read is kept for the next read. The enable bits only gate the interrupt line, with one exception. The frame-sync error bit (which covers a missing or a misaligned frame sync) cannot latch at all while its enable bit is 0. Bits 7, 4 and 2 are reserved, and the live bits are: 6 frame-sync error, 5 test pattern detected, 3 pattern error detected, 1 self-test done, 0 error insertion done.

Top module: `irq_status_ctrl`

## Requirements
- R1: A pulse on a live bit of evt_i sets that status bit, and the bit stays set until status (address 0) is read.
- R2: A read strobe at address 0 puts the status value on rd_data_o in the next cycle and clears the status register at the same clock edge.
- R3: An event in the same cycle as a status read is not in the returned value but is set in the status register afterwards.
- R4: Status bit 6 (frame-sync error) latches only while enable bit 6 is 1. Every other live bit latches whatever its enable bit holds.
- R5: irq_o is a register loaded each cycle with the OR over all bits of (status AND enable), gated by global enable bit 0, so it follows those registers one cycle late.
- R6: Reserved bits 7, 4 and 2 read as 0 in both the status and the enable register. Events on them are ignored.
- R7: A write to address 0 leaves the status register unchanged.
- R8: After reset, status, enable and global enable are 0, and irq_o and rd_data_o are low.
- R9: Address 1 is the enable register (1 = source enabled) and address 2 the global register (bit 0 only, other bits read 0). Both can be written and read back. Address 3 reads 0.
- R10: rd_data_o is 0 in a cycle that follows no read strobe. Reads of addresses 1 to 3 do not change the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | DATA_W | Event pulses, one per status bit position |
| addr_i | input | ADDR_W | Register address |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Read data, valid the cycle after rd_en_i |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
Directed steps first drive every event bit while all enables are 0. This separates bit 6 from the other live bits and from the reserved bits. The same bit is then raised again with its enable set, and a status read is placed in the same cycle as a new event, which shows whether clear or set wins. Global and per-bit enables are toggled while status stays pending, so gating by each of them shows on irq_o on its own. A long run of sparse random events, reads, writes and addresses then follows. A reference model in the bench catches ordering errors between clear, set, enable updates and the one-cycle lag of irq_o.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int IRQ_W      = 8;
    localparam int REG_ADDR_W = 2;

    // status bit positions
    localparam int BIT_FS_ERR   = 6;
    localparam int BIT_PAT_DET  = 5;
    localparam int BIT_PAT_ERR  = 3;
    localparam int BIT_SELFTEST = 1;
    localparam int BIT_INS_DONE = 0;

    localparam logic [IRQ_W-1:0] LIVE_BITS =
        IRQ_W'((1 << BIT_FS_ERR) | (1 << BIT_PAT_DET) | (1 << BIT_PAT_ERR) |
               (1 << BIT_SELFTEST) | (1 << BIT_INS_DONE));

    // register addresses
    localparam int ADR_STATUS = 0;
    localparam int ADR_ENABLE = 1;
    localparam int ADR_GLOBAL = 2;

    typedef struct packed {
        logic rd_status;
        logic rd_enable;
        logic rd_global;
        logic wr_enable;
        logic wr_global;
    } reg_sel_t;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int                DATA_W = irq_pkg::IRQ_W,
    parameter logic [DATA_W-1:0] LIVE   = irq_pkg::LIVE_BITS,
    parameter int                FS_BIT = irq_pkg::BIT_FS_ERR
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [DATA_W-1:0] evt_i,
    input  logic              clr_i,
    input  logic              fs_en_i,
    output logic [DATA_W-1:0] status_o
);
    logic [DATA_W-1:0] status_d, status_q;
    logic [DATA_W-1:0] set_vec;

    always_comb begin
        set_vec = evt_i & LIVE;
        if (!fs_en_i) begin
            set_vec[FS_BIT] = 1'b0;
        end
        // clear first, then set: a simultaneous event survives the read
        status_d = (clr_i ? '0 : status_q) | set_vec;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            status_q <= '0;
        end else begin
            status_q <= status_d;
        end
    end

    assign status_o = status_q;
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
    parameter int                DATA_W = irq_pkg::IRQ_W,
    parameter logic [DATA_W-1:0] LIVE   = irq_pkg::LIVE_BITS
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_enable_i,
    input  logic              wr_global_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] enable_o,
    output logic              gie_o
);
    logic [DATA_W-1:0] enable_d, enable_q;
    logic              gie_d, gie_q;

    always_comb begin
        enable_d = enable_q;
        gie_d    = gie_q;
        if (wr_enable_i) begin
            enable_d = wr_data_i & LIVE;
        end
        if (wr_global_i) begin
            gie_d = wr_data_i[0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            enable_q <= '0;
            gie_q    <= 1'b0;
        end else begin
            enable_q <= enable_d;
            gie_q    <= gie_d;
        end
    end

    assign enable_o = enable_q;
    assign gie_o    = gie_q;
endmodule

// File: rtl/irq_out_gen.sv
module irq_out_gen #(
    parameter int DATA_W = irq_pkg::IRQ_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [DATA_W-1:0] status_i,
    input  logic [DATA_W-1:0] enable_i,
    input  logic              gie_i,
    output logic              irq_o
);
    logic irq_d, irq_q;

    always_comb begin
        irq_d = gie_i & (|(status_i & enable_i));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
    parameter int DATA_W = irq_pkg::IRQ_W,
    parameter int ADDR_W = irq_pkg::REG_ADDR_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [DATA_W-1:0] evt_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_o
);
    import irq_pkg::*;

    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(ADR_STATUS);
    localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(ADR_ENABLE);
    localparam logic [ADDR_W-1:0] A_GLOBAL = ADDR_W'(ADR_GLOBAL);

    reg_sel_t          sel;
    logic [DATA_W-1:0] status_w, enable_w;
    logic              gie_w;
    logic [DATA_W-1:0] rdata_d, rdata_q;

    always_comb begin
        sel.rd_status = rd_en_i && (addr_i == A_STATUS);
        sel.rd_enable = rd_en_i && (addr_i == A_ENABLE);
        sel.rd_global = rd_en_i && (addr_i == A_GLOBAL);
        sel.wr_enable = wr_en_i && (addr_i == A_ENABLE);
        sel.wr_global = wr_en_i && (addr_i == A_GLOBAL);
    end

    irq_status_bank #(.DATA_W(DATA_W)) u_status (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .evt_i    (evt_i),
        .clr_i    (sel.rd_status),
        .fs_en_i  (enable_w[BIT_FS_ERR]),
        .status_o (status_w)
    );

    irq_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_enable_i (sel.wr_enable),
        .wr_global_i (sel.wr_global),
        .wr_data_i   (wr_data_i),
        .enable_o    (enable_w),
        .gie_o       (gie_w)
    );

    irq_out_gen #(.DATA_W(DATA_W)) u_irq (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .status_i (status_w),
        .enable_i (enable_w),
        .gie_i    (gie_w),
        .irq_o    (irq_o)
    );

    always_comb begin
        rdata_d = '0;
        if (sel.rd_status) begin
            rdata_d = status_w;
        end else if (sel.rd_enable) begin
            rdata_d = enable_w;
        end else if (sel.rd_global) begin
            rdata_d = DATA_W'(gie_w);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rd_data_o = rdata_q;
endmodule

// File: rtl/irq_status_ctrl_chk.sv
module irq_status_ctrl_chk #(
    parameter int DATA_W = irq_pkg::IRQ_W,
    parameter int ADDR_W = irq_pkg::REG_ADDR_W
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [DATA_W-1:0] evt_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              rd_en_i,
    input logic [DATA_W-1:0] rd_data_o,
    input logic              irq_o,
    input logic [DATA_W-1:0] status_q,
    input logic [DATA_W-1:0] enable_q,
    input logic              gie_q
);
    import irq_pkg::*;

    logic rd_st;
    assign rd_st = rd_en_i && (addr_i == ADDR_W'(ADR_STATUS));

    assert_sticky_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_st |=> ((status_q & $past(status_q)) == $past(status_q)));

    assert_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_st && (evt_i == '0)) |=> (status_q == '0));

    assert_keep_new_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_st && evt_i[BIT_INS_DONE]) |=> status_q[BIT_INS_DONE]);

    assert_fs_block_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!enable_q[BIT_FS_ERR] && !status_q[BIT_FS_ERR]) |=> !status_q[BIT_FS_ERR]);

    assert_irq_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !gie_q |=> !irq_o);

    assert_irq_src_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> $past((status_q & enable_q) != '0));

    assert_rsvd_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((status_q | enable_q) & ~LIVE_BITS) == '0);

    assert_idle_rdata_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> (rd_data_o == '0));
endmodule

bind irq_status_ctrl irq_status_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt_i),
    .addr_i    (addr_i),
    .rd_en_i   (rd_en_i),
    .rd_data_o (rd_data_o),
    .irq_o     (irq_o),
    .status_q  (status_w),
    .enable_q  (enable_w),
    .gie_q     (gie_w)
);

// File: tb/irq_status_ctrl_tb_top.sv
module irq_status_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int AW = 2;
    localparam logic [DW-1:0] LIVE = 8'h6B;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] evt = '0;
    logic [AW-1:0] addr = '0;
    logic          rd_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [DW-1:0] m_st = '0, m_en = '0;
    logic          m_g = 1'b0;
    logic [DW-1:0] exp_rd = '0;
    logic          exp_irq = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_status_ctrl #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .addr_i(addr),
        .rd_en_i(rd_en), .wr_en_i(wr_en), .wr_data_i(wdata),
        .rd_data_o(rdata), .irq_o(irq)
    );

    function automatic logic [DW-1:0] read_val(logic [AW-1:0] a);
        case (a)
            2'd0: return m_st;
            2'd1: return m_en;
            2'd2: return {{(DW-1){1'b0}}, m_g};
            default: return '0;
        endcase
    endfunction

    function automatic logic [DW-1:0] next_status(logic [DW-1:0] e, logic rd, logic [AW-1:0] a);
        logic [DW-1:0] s;
        logic [DW-1:0] setv;
        s = (rd && a == 2'd0) ? '0 : m_st;
        setv = e & LIVE;
        if (!m_en[6]) setv[6] = 1'b0;
        return s | setv;
    endfunction

    task automatic check(string req);
        n_chk += 2;
        if (rdata !== exp_rd) begin
            n_bad++;
            $display("FAIL %s: rd_data_o=%h expected %h", req, rdata, exp_rd);
        end
        if (irq !== exp_irq) begin
            n_bad++;
            $display("FAIL %s: irq_o=%b expected %b", req, irq, exp_irq);
        end
    endtask

    // called at a falling edge: drive, advance model, wait, check
    task automatic step(logic [DW-1:0] e, logic rd, logic wr, logic [AW-1:0] a,
                        logic [DW-1:0] d, string req);
        evt = e; rd_en = rd; wr_en = wr; addr = a; wdata = d;
        exp_irq = m_g & (|(m_st & m_en));
        exp_rd  = rd ? read_val(a) : '0;
        m_st = next_status(e, rd, a);
        if (wr && a == 2'd1) m_en = d & LIVE;
        if (wr && a == 2'd2) m_g = d[0];
        @(negedge clk);
        check(req);
    endtask

    task automatic idle(string req);
        step('0, 1'b0, 1'b0, '0, '0, req);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8");
        rst_n = 1'b1;
        idle("R8");
        step('0, 1'b1, 1'b0, 2'd0, '0, "R8");
        idle("R8");
        // R4, R6: all events with enables 0
        step(8'hFF, 1'b0, 1'b0, '0, '0, "R4");
        idle("R1");
        idle("R1");
        step('0, 1'b1, 1'b0, 2'd0, '0, "R6");   // expect 2B
        step('0, 1'b1, 1'b0, 2'd0, '0, "R2");   // cleared -> 00
        idle("R2");
        // R7: status write ignored
        step(8'h21, 1'b0, 1'b0, '0, '0, "R1");
        step('0, 1'b0, 1'b1, 2'd0, 8'hFF, "R7");
        step('0, 1'b0, 1'b1, 2'd0, 8'h00, "R7");
        step('0, 1'b1, 1'b0, 2'd0, '0, "R7");
        idle("R7");
        // R9: enable/global registers
        step('0, 1'b0, 1'b1, 2'd1, 8'hFF, "R9");
        step('0, 1'b1, 1'b0, 2'd1, '0, "R9");
        step('0, 1'b0, 1'b1, 2'd2, 8'hFF, "R9");
        step('0, 1'b1, 1'b0, 2'd2, '0, "R9");
        step('0, 1'b1, 1'b0, 2'd3, '0, "R9");
        idle("R9");
        // R4: frame-sync error latches when enabled; R5 irq follows
        step(8'h40, 1'b0, 1'b0, '0, '0, "R4");
        idle("R5");
        idle("R5");
        // R10: non-status reads keep status
        step('0, 1'b1, 1'b0, 2'd1, '0, "R10");
        step('0, 1'b1, 1'b0, 2'd2, '0, "R10");
        idle("R10");
        // R3: event during status read
        step(8'h01, 1'b1, 1'b0, 2'd0, '0, "R3");
        idle("R3");
        step('0, 1'b1, 1'b0, 2'd0, '0, "R3");
        idle("R3");
        // R5: global off gates irq, per-bit enable gates irq
        step(8'h08, 1'b0, 1'b0, '0, '0, "R5");
        step('0, 1'b0, 1'b1, 2'd2, 8'h00, "R5");
        idle("R5");
        step('0, 1'b0, 1'b1, 2'd2, 8'h01, "R5");
        step('0, 1'b0, 1'b1, 2'd1, 8'h00, "R5");
        idle("R5");
        idle("R5");
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [DW-1:0] e;
            logic r, w;
            e = DW'($urandom & $urandom & $urandom);
            r = ($urandom % 10) < 3;
            w = ($urandom % 10) < 2;
            step(e, r, w, AW'($urandom), DW'($urandom), "R5");
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule